// File: doc/BRIEF.md
# Partitioned Edge Mask Generator

This block produces the partial-write byte mask that a SIMD store needs at the two ends of a run of pixels. It takes a start address and an end address, picks the start element inside its aligned 8-byte block, and marks every element from there to the end of the block. When the end address lies in the same aligned block, the mask is also cut back so that it stops at the end element. Elements may be 8, 16 or 32 bits wide, so the mask has eight, four or two meaningful bits. The bit order can place the lowest-addressed element either at the top of the mask or at the bottom.

A set-flags option also yields integer condition codes for the subtraction of the end address from the start address, in both 64-bit and 32-bit forms. When the option is off, the previous flags are kept. A narrow mode drops the upper 32 address bits before the mask and the block comparison are formed. The flags always use the full 64-bit inputs.

All results are registered and appear one clock after the inputs are presented. No memory access takes place inside the block.

Top module: `edge_mask_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `mask_o`, `flags_o` and `flags_valid_o` become zero.
- R2: Size code 0, big-endian (`little_i`=0), offset k = address bits 2:0. The start mask is 8'hFF shifted right by k. The end mask has its top k+1 bits set, so the lowest-addressed byte maps to mask bit 7.
- R3: Size code 0, little-endian (`little_i`=1). The start mask is 8'hFF shifted left by k, truncated to 8 bits. The end mask has its low k+1 bits set, so the lowest-addressed byte maps to mask bit 0.
- R4: Size code 1 (16-bit elements), k = address bits 2:1. The masks are 4 bits wide and built with the same rules as R2 and R3 for the chosen order. `mask_o[7:4]` is zero.
- R5: Size code 2 (32-bit elements), k = address bit 2. Big-endian start masks are 3 and 1 and end masks are 2 and 3. Little-endian start masks are 3 and 2 and end masks are 1 and 3. `mask_o[7:2]` is zero. Size code 3 behaves as size code 0.
- R6: If both addresses are equal after their low three bits are cleared, the output mask is the start mask ANDed with the end mask. Otherwise it is the start mask alone.
- R7: With `narrow_i`=1, both addresses are cut to their low 32 bits before the offsets and the block comparison are formed. Addresses that differ only above bit 31 then count as the same block.
- R8: With `set_cc_i`=1, `flags_o` receives the flags of `addr_a_i - addr_b_i`, computed on the full 64-bit inputs even in narrow mode. Bits 7:4 hold the 64-bit N,Z,V,C and bits 3:0 hold the 32-bit N,Z,V,C, where C is the unsigned borrow. `flags_valid_o` is 1.
- R9: With `set_cc_i`=0, `flags_o` keeps its previous value and `flags_valid_o` is 0.
- R10: Each result reflects the inputs that were present at the preceding rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_a_i | input | 64 | Start address |
| addr_b_i | input | 64 | End address |
| elem_size_i | input | 2 | 0: 8-bit, 1: 16-bit, 2: 32-bit, 3: as 0 |
| little_i | input | 1 | 1 selects little-endian mask order |
| set_cc_i | input | 1 | 1 updates the flags |
| narrow_i | input | 1 | 1 truncates addresses to 32 bits for the mask |
| mask_o | output | 8 | Element write mask, zero-extended |
| flags_o | output | 8 | {64-bit NZVC, 32-bit NZVC} |
| flags_valid_o | output | 1 | High when the flags were updated by this result |

## Verification
The assertions assume that every input holds a known value at each rising edge after reset, and that the size code, endian bit and set-flags bit of any cycle describe that cycle's addresses. The properties about equal addresses and about start-aligned blocks only fire when those address relations hold at the sampled edge. The bench therefore changes its stimulus only on falling edges and never leaves an input undriven. Its random phase pairs each start address with an end address that is near it, so same-block and cross-block cases, equal-address zero flags, and narrow-mode aliasing of the high half all occur.

// File: rtl/edge_mask_pkg.sv
package edge_mask_pkg;

    localparam int ADDR_W    = 64;
    localparam int NARROW_W  = 32;
    localparam int BLOCK_LSB = 3;
    localparam int MASK_W    = 1 << BLOCK_LSB;
    localparam int N_SIZES   = 3;

    typedef enum logic [1:0] {
        ESZ_BYTE = 2'd0,
        ESZ_HALF = 2'd1,
        ESZ_WORD = 2'd2,
        ESZ_RSVD = 2'd3
    } esz_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } cc_t;

    typedef struct packed {
        cc_t wide;
        cc_t narrow;
    } cc_pair_t;

    function automatic logic [1:0] size_index(input esz_e sz);
        case (sz)
            ESZ_HALF: return 2'd1;
            ESZ_WORD: return 2'd2;
            default:  return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/edge_side_mask.sv
module edge_side_mask #(
    parameter int LANES = 8,
    localparam int IDXW = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic [IDXW-1:0]  start_k,
    input  logic [IDXW-1:0]  end_k,
    input  logic             little,
    output logic [LANES-1:0] start_mask,
    output logic [LANES-1:0] end_mask
);
    localparam logic [LANES-1:0] ONES = '1;

    always_comb begin
        if (little) begin
            start_mask = ONES << start_k;
            end_mask   = ONES >> (LANES - 1 - int'(end_k));
        end else begin
            start_mask = ONES >> start_k;
            end_mask   = ~(ONES >> (int'(end_k) + 1));
        end
    end

endmodule

// File: rtl/edge_flag_calc.sv
module edge_flag_calc
    import edge_mask_pkg::*;
#(
    parameter int W = 64
) (
    input  logic [W-1:0] lhs,
    input  logic [W-1:0] rhs,
    output cc_t          cc
);
    logic [W:0] diff;

    always_comb begin
        diff = {1'b0, lhs} - {1'b0, rhs};
        cc.n = diff[W-1];
        cc.z = (diff[W-1:0] == '0);
        cc.v = (lhs[W-1] ^ rhs[W-1]) & (diff[W-1] ^ lhs[W-1]);
        cc.c = diff[W];
    end

endmodule

// File: rtl/edge_mask_unit.sv
module edge_mask_unit
    import edge_mask_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [63:0] addr_a_i,
    input  logic [63:0] addr_b_i,
    input  logic [1:0]  elem_size_i,
    input  logic        little_i,
    input  logic        set_cc_i,
    input  logic        narrow_i,
    output logic [7:0]  mask_o,
    output logic [7:0]  flags_o,
    output logic        flags_valid_o
);
    logic [ADDR_W-1:0] eff_a, eff_b;
    logic              same_block;
    logic [MASK_W-1:0] start_all [N_SIZES];
    logic [MASK_W-1:0] end_all   [N_SIZES];
    logic [1:0]        sel;
    logic [MASK_W-1:0] mask_d;
    cc_pair_t          cc_d;

    // Narrow mode clears the upper half before the mask is formed
    always_comb begin
        eff_a = narrow_i ? {{(ADDR_W-NARROW_W){1'b0}}, addr_a_i[NARROW_W-1:0]} : addr_a_i;
        eff_b = narrow_i ? {{(ADDR_W-NARROW_W){1'b0}}, addr_b_i[NARROW_W-1:0]} : addr_b_i;
        same_block = (eff_a[ADDR_W-1:BLOCK_LSB] == eff_b[ADDR_W-1:BLOCK_LSB]);
    end

    // One mask builder per element size; size g has MASK_W>>g lanes
    for (genvar g = 0; g < N_SIZES; g++) begin : g_size
        localparam int LANES = MASK_W >> g;
        logic [LANES-1:0] s_m, e_m;

        edge_side_mask #(.LANES(LANES)) u_side (
            .start_k    (eff_a[BLOCK_LSB-1:g]),
            .end_k      (eff_b[BLOCK_LSB-1:g]),
            .little     (little_i),
            .start_mask (s_m),
            .end_mask   (e_m)
        );

        assign start_all[g] = MASK_W'(s_m);
        assign end_all[g]   = MASK_W'(e_m);
    end

    always_comb begin
        sel    = size_index(esz_e'(elem_size_i));
        mask_d = same_block ? (start_all[sel] & end_all[sel]) : start_all[sel];
    end

    edge_flag_calc #(.W(ADDR_W)) u_cc_wide (
        .lhs (addr_a_i),
        .rhs (addr_b_i),
        .cc  (cc_d.wide)
    );

    edge_flag_calc #(.W(NARROW_W)) u_cc_narrow (
        .lhs (addr_a_i[NARROW_W-1:0]),
        .rhs (addr_b_i[NARROW_W-1:0]),
        .cc  (cc_d.narrow)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_o        <= '0;
            flags_o       <= '0;
            flags_valid_o <= 1'b0;
        end else begin
            mask_o        <= mask_d;
            flags_valid_o <= set_cc_i;
            if (set_cc_i) begin
                flags_o <= cc_d;
            end
        end
    end

    // R4: upper half of the mask stays clear for 16-bit elements
    a_r4_half_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (elem_size_i == 2'd1) |=> (mask_o[7:4] == 4'h0));

    // R5: only two mask bits can be set for 32-bit elements
    a_r5_word_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (elem_size_i == 2'd2) |=> (mask_o[7:2] == 6'h00));

    // R6: identical byte addresses leave exactly one byte enabled
    a_r6_equal_single: assert property (@(posedge clk) disable iff (rst)
        ((elem_size_i == 2'd0) && (addr_a_i == addr_b_i)) |=> ($countones(mask_o) == 1));

    // R6: aligned start in another block enables every byte
    a_r6_cross_full: assert property (@(posedge clk) disable iff (rst)
        ((elem_size_i == 2'd0) && (addr_a_i[2:0] == 3'd0) &&
         (addr_a_i[31:3] != addr_b_i[31:3])) |=> (mask_o == 8'hFF));

    // R8: equal operands give zero in both flag sets
    a_r8_zero_flags: assert property (@(posedge clk) disable iff (rst)
        (set_cc_i && (addr_a_i == addr_b_i)) |=> (flags_o[6] && flags_o[2] && flags_valid_o));

    // R9: flags are held when no update is requested
    a_r9_flags_hold: assert property (@(posedge clk) disable iff (rst)
        !set_cc_i |=> ($stable(flags_o) && !flags_valid_o));

endmodule

// File: tb/edge_mask_unit_tb.sv
module edge_mask_unit_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] addr_a_i = '0;
    logic [63:0] addr_b_i = '0;
    logic [1:0]  elem_size_i = '0;
    logic        little_i = 1'b0;
    logic        set_cc_i = 1'b0;
    logic        narrow_i = 1'b0;
    logic [7:0]  mask_o;
    logic [7:0]  flags_o;
    logic        flags_valid_o;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    logic [7:0] model_flags = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    edge_mask_unit u_dut (
        .clk           (clk),
        .rst           (rst),
        .addr_a_i      (addr_a_i),
        .addr_b_i      (addr_b_i),
        .elem_size_i   (elem_size_i),
        .little_i      (little_i),
        .set_cc_i      (set_cc_i),
        .narrow_i      (narrow_i),
        .mask_o        (mask_o),
        .flags_o       (flags_o),
        .flags_valid_o (flags_valid_o)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired: got %0d cycles exp <= %0d", cycles, WATCHDOG);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    // Element-wise reference: lane j is enabled from the start element
    // onward, and up to the end element when both lie in one block.
    function automatic logic [7:0] ref_mask(logic [63:0] a, logic [63:0] b,
                                            int sz, bit le, bit nar);
        logic [7:0] m = '0;
        int lanes = (sz == 1) ? 4 : (sz == 2) ? 2 : 8;
        int ebytes = 8 / lanes;
        longint unsigned ua, ub;
        int ka, kb;
        bit same;
        ua = nar ? (a & 64'h0000_0000_FFFF_FFFF) : a;
        ub = nar ? (b & 64'h0000_0000_FFFF_FFFF) : b;
        ka = int'(ua % 8) / ebytes;
        kb = int'(ub % 8) / ebytes;
        same = (ua / 8) == (ub / 8);
        for (int j = 0; j < lanes; j++) begin
            int pos = le ? j : lanes - 1 - j;
            bit on = (j >= ka) && (!same || j <= kb);
            m[pos] = on;
        end
        return m;
    endfunction

    function automatic logic [3:0] ref_cc(longint unsigned a, longint unsigned b, int w);
        longint unsigned msk = (w == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
        longint unsigned x = a & msk;
        longint unsigned y = b & msk;
        longint unsigned d = (x - y) & msk;
        bit n = (w == 64) ? d[63] : d[31];
        bit z = (d == 0);
        bit c = (x < y);
        bit slt;
        if (w == 64) slt = $signed(x) < $signed(y);
        else         slt = $signed(x[31:0]) < $signed(y[31:0]);
        return {n, z, (slt != n), c};
    endfunction

    task automatic check8(string tag, string what, logic [7:0] got, logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: got %h exp %h", tag, what, got, exp);
        end
    endtask

    // R10: inputs applied at a falling edge are checked one falling edge later
    task automatic step(logic [63:0] a, logic [63:0] b, int sz, bit le, bit cc, bit nar, string tag);
        logic [7:0] em;
        string mtag;
        addr_a_i = a; addr_b_i = b; elem_size_i = 2'(sz);
        little_i = le; set_cc_i = cc; narrow_i = nar;
        em = ref_mask(a, b, sz, le, nar);
        if (cc) model_flags = {ref_cc(a, b, 64), ref_cc(a, b, 32)};
        @(negedge clk);
        if (tag.len() != 0) mtag = tag;
        else if (sz == 1) mtag = "R4";
        else if (sz == 2) mtag = "R5";
        else mtag = le ? "R3" : "R2";
        check8(mtag, "mask", mask_o, em);
        check8(cc ? "R8" : "R9", "flags", flags_o, model_flags);
        check8(cc ? "R8" : "R9", "flags_valid", {7'd0, flags_valid_o}, {7'd0, cc});
    endtask

    initial begin
        // R1: reset state
        @(negedge clk);
        @(negedge clk);
        check8("R1", "mask", mask_o, 8'h00);
        check8("R1", "flags", flags_o, 8'h00);
        check8("R1", "flags_valid", {7'd0, flags_valid_o}, 8'h00);
        rst = 1'b0;

        // R2 / R3: every byte offset, equal addresses and cross-block
        for (int k = 0; k < 8; k++) begin
            step(64'h1000 + 64'(k), 64'h1000 + 64'(k), 0, 1'b0, 1'b0, 1'b0, "R2");
            step(64'h1000 + 64'(k), 64'h2007, 0, 1'b0, 1'b0, 1'b0, "R2");
            step(64'h1000 + 64'(k), 64'h1000 + 64'(7 - k), 0, 1'b1, 1'b0, 1'b0, "R3");
            step(64'h1000 + 64'(k), 64'h0FF8, 0, 1'b1, 1'b0, 1'b0, "R3");
        end
        // R4 / R5: wider elements in both orders
        for (int k = 0; k < 8; k += 2) begin
            step(64'h40 + 64'(k), 64'h46, 1, 1'b0, 1'b0, 1'b0, "R4");
            step(64'h40 + 64'(k), 64'h41, 1, 1'b1, 1'b0, 1'b0, "R4");
            step(64'h40 + 64'(k), 64'h80, 1, 1'b1, 1'b0, 1'b0, "R4");
        end
        step(64'h44, 64'h44, 2, 1'b0, 1'b0, 1'b0, "R5");
        step(64'h40, 64'h43, 2, 1'b0, 1'b0, 1'b0, "R5");
        step(64'h44, 64'h44, 2, 1'b1, 1'b0, 1'b0, "R5");
        step(64'h40, 64'h41, 2, 1'b1, 1'b0, 1'b0, "R5");
        step(64'h45, 64'h45, 3, 1'b0, 1'b0, 1'b0, "R5");
        // R6: same block combines, neighbouring block does not
        step(64'h202, 64'h205, 0, 1'b0, 1'b0, 1'b0, "R6");
        step(64'h202, 64'h20D, 0, 1'b0, 1'b0, 1'b0, "R6");
        // R7: upper half ignored only in narrow mode
        step(64'h1_0000_0203, 64'h2_0000_0205, 0, 1'b0, 1'b0, 1'b1, "R7");
        step(64'h1_0000_0203, 64'h2_0000_0205, 0, 1'b0, 1'b0, 1'b0, "R7");
        // R8: flags from full addresses, including narrow mode
        step(64'h5, 64'h5, 0, 1'b0, 1'b1, 1'b0, "");
        step(64'h3, 64'h9, 0, 1'b0, 1'b1, 1'b0, "");
        step(64'h8000_0000_0000_0000, 64'h1, 0, 1'b0, 1'b1, 1'b1, "");
        step(64'h0000_0000_8000_0000, 64'h1, 0, 1'b0, 1'b1, 1'b0, "");
        // R9: flags held across no-update cycles
        step(64'h7, 64'h100, 0, 1'b0, 1'b0, 1'b0, "");
        step(64'h100, 64'h7, 1, 1'b1, 1'b0, 1'b1, "");

        // Random phase: end address near the start address
        for (int i = 0; i < 600; i++) begin
            logic [63:0] a, b;
            a = {$urandom(), $urandom()};
            case ($urandom_range(0, 3))
                0: b = a;
                1: b = a + 64'($urandom_range(0, 15)) - 64'd8;
                2: b = {$urandom(), a[31:0]};
                default: b = {$urandom(), $urandom()};
            endcase
            step(a, b, int'($urandom_range(0, 3)), 1'($urandom()), 1'($urandom()),
                 1'($urandom()), "");
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule